// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a clocked request interface to an external asynchronous static RAM that holds 128K words of 16 bits. A requester presents a read or write together with a word address, write data and a per-byte enable mask. The controller then runs one bus cycle on the memory pins: active-low chip select, output enable, write enable and one select strobe for each byte lane. A read finishes with a one-cycle response strobe that carries the captured word.

All memory timing comes from counting clock cycles. Each nanosecond figure of the chosen speed grade is divided by the clock period parameter and rounded up. The controller drives the shared data bus through an output enable, so the tri-state pad can live outside the block. During a write it keeps address and data steady for the whole strobe overlap and raises write enable one cycle before it lets them go. A write that follows a read waits one extra cycle so that the memory has released the bus.

Top module: `sram_byte_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, output enable, write enable and both byte selects are high, the data output enable is low and `req_ready` is high.
- R2: While no access is in progress, `req_ready` is high and chip select, output enable, write enable and both byte selects are high. Chip select is never low while `req_ready` is high.
- R3: A read with a non-zero mask holds chip select and output enable low, with write enable high, for RD cycles. RD is the rounded-up number of clock periods in the grade's cycle time: 55, 70 or 100 ns for grade 0, 1 or 2. `rsp_valid` is high for the cycle that begins RD rising edges after the accepting edge, and the block is ready again in that cycle.
- R4: Mask bit 0 selects bits 7:0 and drives `mem_bsel_n[0]` low. Mask bit 1 selects bits 15:8 and drives `mem_bsel_n[1]` low. A byte lane that is not selected has its strobe high for the whole access and reads back as zero.
- R5: A write with a non-zero mask holds write enable low for WP cycles, with chip select low, output enable high and the data output enable high. WP is the largest rounded-up value of the write pulse (45/60/80 ns), the address-to-write-end time (50/65/80 ns) and the data setup time (25/30/40 ns).
- R6: Write enable rises one cycle before chip select, the byte selects and the data output enable are released. A write keeps chip select low for max(WP+1, RD) cycles.
- R7: Address, byte selects and write data stay constant for as long as chip select stays low in one access.
- R8: The data output enable is never high while output enable is low. In a write accepted after a read, one extra cycle passes before the data bus is driven.
- R9: A request with an all-zero mask starts no bus cycle. The block is ready again in the next cycle, a zero-mask read returns `rsp_valid` with zero data in that cycle, and memory contents are unchanged.
- R10: The cycle counts follow from the default parameters (grade 1, 10 ns clock): RD = 7, WP = 7, and a write keeps chip select low for 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable mask, bit 0 = low byte |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, deselected bytes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_bsel_n | output | 2 | Byte lane selects, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 16 | Data from memory |

## Verification
Every result comes a fixed number of edges after the accepting edge. A read response appears RD edges later. A write releases the bus max(WP+1, RD) edges later, or one edge later again when a read went before it. A zero-mask request finishes after one edge. Each scenario task samples the pins at every falling edge after acceptance and numbers those samples. It checks the index where the block turns ready, where the data bus is first driven and where the response appears against those counts, and it counts the low strobe cycles inside the window. The bench's memory model drives a fixed pattern on deselected lanes, so a missing lane mask shows up as a wrong response value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_TURN  = 3'd1,
      ST_RD    = 3'd2,
      ST_WR    = 3'd3,
      ST_WHOLD = 3'd4
   } sram_st_e;

   function automatic int unsigned ceil_div(input int unsigned ns, input int unsigned per);
      return (ns + per - 1) / per;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // cycle time (also address access time) per grade
   function automatic int unsigned cyc_ns(input int unsigned g);
      case (g)
         0:       return 55;
         1:       return 70;
         default: return 100;
      endcase
   endfunction

   function automatic int unsigned pulse_ns(input int unsigned g);
      case (g)
         0:       return 45;
         1:       return 60;
         default: return 80;
      endcase
   endfunction

   function automatic int unsigned aw_ns(input int unsigned g);
      case (g)
         0:       return 50;
         1:       return 65;
         default: return 80;
      endcase
   endfunction

   function automatic int unsigned setup_ns(input int unsigned g);
      case (g)
         0:       return 25;
         1:       return 30;
         default: return 40;
      endcase
   endfunction

   function automatic int unsigned rd_cycles(input int unsigned g, input int unsigned per);
      return max2(1, ceil_div(cyc_ns(g), per));
   endfunction

   function automatic int unsigned wp_cycles(input int unsigned g, input int unsigned per);
      return max2(1, max2(ceil_div(pulse_ns(g), per),
                          max2(ceil_div(aw_ns(g), per), ceil_div(setup_ns(g), per))));
   endfunction

   function automatic int unsigned wr_cycles(input int unsigned g, input int unsigned per);
      return max2(wp_cycles(g, per) + 1, ceil_div(cyc_ns(g), per));
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned RD_CYC = 7,
   parameter int unsigned WP_CYC = 7,
   parameter int unsigned WR_TOT = 8
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     req_write,
   input  logic     mask_zero,
   output logic     req_ready,
   output logic     accept,
   output sram_st_e state_d,
   output logic     rd_last,
   output logic     zero_rd
);

   localparam int unsigned MAXC  = (RD_CYC > WR_TOT) ? RD_CYC : WR_TOT;
   localparam int unsigned CNT_W = $clog2(MAXC + 1);
   localparam int unsigned HOLD_CYC = WR_TOT - WP_CYC;

   sram_st_e         state_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             last_rd_q, last_rd_d;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid & req_ready;
   assign rd_last   = (state_q == ST_RD) && (cnt_q == '0);
   assign zero_rd   = accept & mask_zero & ~req_write;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      last_rd_d = last_rd_q;
      case (state_q)
         ST_IDLE: begin
            if (accept && !mask_zero) begin
               if (!req_write) begin
                  state_d = ST_RD;
                  cnt_d   = CNT_W'(RD_CYC - 1);
               end else if (last_rd_q) begin
                  state_d = ST_TURN;
               end else begin
                  state_d   = ST_WR;
                  cnt_d     = CNT_W'(WP_CYC - 1);
                  last_rd_d = 1'b0;
               end
            end
         end
         ST_TURN: begin
            state_d   = ST_WR;
            cnt_d     = CNT_W'(WP_CYC - 1);
            last_rd_d = 1'b0;
         end
         ST_RD: begin
            if (cnt_q == '0) begin
               state_d   = ST_IDLE;
               last_rd_d = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_WR: begin
            if (cnt_q == '0) begin
               state_d = ST_WHOLD;
               cnt_d   = CNT_W'(HOLD_CYC - 1);
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         ST_WHOLD: begin
            if (cnt_q == '0) state_d = ST_IDLE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         last_rd_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         cnt_q     <= cnt_d;
         last_rd_q <= last_rd_d;
      end
   end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 17
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  sram_st_e          state_d,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_dq_oe
);

   logic busy_d;
   assign busy_d = (state_d == ST_RD) || (state_d == ST_WR) || (state_d == ST_WHOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         if (accept) mem_addr <= req_addr;
         mem_ce_n  <= ~busy_d;
         mem_oe_n  <= ~(state_d == ST_RD);
         mem_we_n  <= ~(state_d == ST_WR);
         mem_dq_oe <= (state_d == ST_WR) || (state_d == ST_WHOLD);
      end
   end

endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned LANE_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              sel_in,
   input  logic [LANE_W-1:0] wdata_in,
   input  sram_st_e          state_d,
   input  logic              rd_last,
   input  logic              zero_rd,
   input  logic [LANE_W-1:0] dq_in,
   output logic              bsel_n,
   output logic [LANE_W-1:0] dq_out,
   output logic [LANE_W-1:0] rdata
);

   logic sel_q, sel_nxt, busy_d;

   assign sel_nxt = accept ? sel_in : sel_q;
   assign busy_d  = (state_d == ST_RD) || (state_d == ST_WR) || (state_d == ST_WHOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         dq_out <= '0;
         bsel_n <= 1'b1;
         rdata  <= '0;
      end else begin
         sel_q  <= sel_nxt;
         if (accept) dq_out <= wdata_in;
         bsel_n <= ~(busy_d & sel_nxt);
         if (rd_last)      rdata <= sel_q ? dq_in : '0;
         else if (zero_rd) rdata <= '0;
      end
   end

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANE_W = 8,
   parameter int unsigned CLK_NS = 10,
   parameter int unsigned GRADE  = 1,
   localparam int unsigned NLANE = DATA_W / LANE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [NLANE-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [NLANE-1:0]  mem_bsel_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned RD_CYC = rd_cycles(GRADE, CLK_NS);
   localparam int unsigned WP_CYC = wp_cycles(GRADE, CLK_NS);
   localparam int unsigned WR_TOT = wr_cycles(GRADE, CLK_NS);

   if (DATA_W % LANE_W != 0 || NLANE < 1) begin : g_bad_width
      $error("DATA_W must be a non-zero multiple of LANE_W");
   end
   if (GRADE > 2) begin : g_bad_grade
      $error("GRADE must be 0, 1 or 2");
   end
   if (CLK_NS == 0 || ADDR_W == 0) begin : g_bad_clk
      $error("CLK_NS and ADDR_W must be non-zero");
   end

   sram_st_e state_d;
   logic     accept, rd_last, zero_rd;

   sram_ctrl_seq #(
      .RD_CYC (RD_CYC),
      .WP_CYC (WP_CYC),
      .WR_TOT (WR_TOT)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .mask_zero (req_be == '0),
      .req_ready (req_ready),
      .accept    (accept),
      .state_d   (state_d),
      .rd_last   (rd_last),
      .zero_rd   (zero_rd)
   );

   sram_ctrl_pins #(.ADDR_W(ADDR_W)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .state_d   (state_d),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_dq_oe (mem_dq_oe)
   );

   for (genvar i = 0; i < NLANE; i++) begin : g_lane
      sram_ctrl_lane #(.LANE_W(LANE_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .accept   (accept),
         .sel_in   (req_be[i]),
         .wdata_in (req_wdata[i*LANE_W +: LANE_W]),
         .state_d  (state_d),
         .rd_last  (rd_last),
         .zero_rd  (zero_rd),
         .dq_in    (mem_dq_in[i*LANE_W +: LANE_W]),
         .bsel_n   (mem_bsel_n[i]),
         .dq_out   (mem_dq_out[i*LANE_W +: LANE_W]),
         .rdata    (rsp_rdata[i*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= rd_last | zero_rd;
   end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
   import sram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NLANE  = 2,
   parameter int unsigned CLK_NS = 10,
   parameter int unsigned GRADE  = 1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [NLANE-1:0]  mem_bsel_n,
   input logic [DATA_W-1:0] mem_dq_out,
   input logic              mem_dq_oe
);

   localparam int unsigned RD_CYC = rd_cycles(GRADE, CLK_NS);
   localparam int unsigned WP_CYC = wp_cycles(GRADE, CLK_NS);

   int unsigned we_lo_cnt, oe_lo_cnt, oe_hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_lo_cnt <= 0;
         oe_lo_cnt <= 0;
         oe_hi_cnt <= 3;
      end else begin
         we_lo_cnt <= mem_we_n ? 0 : we_lo_cnt + 1;
         oe_lo_cnt <= mem_oe_n ? 0 : oe_lo_cnt + 1;
         oe_hi_cnt <= !mem_oe_n ? 0 : ((oe_hi_cnt >= 3) ? 3 : oe_hi_cnt + 1);
      end
   end

   p_idle_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && (&mem_bsel_n)));

   p_rsp_when_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);

   p_read_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> (oe_lo_cnt == RD_CYC));

   p_write_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe && !(&mem_bsel_n)));

   p_write_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_cnt == WP_CYC));

   p_we_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

   p_addr_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_bsel_n)));

   p_no_contend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   p_turn_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (oe_hi_cnt >= 2));

endmodule

bind sram_byte_ctrl sram_ctrl_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .NLANE  (NLANE),
   .CLK_NS (CLK_NS),
   .GRADE  (GRADE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_addr   (mem_addr),
   .mem_ce_n   (mem_ce_n),
   .mem_oe_n   (mem_oe_n),
   .mem_we_n   (mem_we_n),
   .mem_bsel_n (mem_bsel_n),
   .mem_dq_out (mem_dq_out),
   .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_sram_byte_ctrl.sv
module sim_sram_byte_ctrl;

   localparam int CLK_PER = 10;
   localparam int EXP_RD  = 7;
   localparam int EXP_WP  = 7;
   localparam int EXP_WT  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]  mem_bsel_n;
   logic [15:0] mem_dq_out, mem_dq_in;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PER/2) clk = ~clk;

   sram_byte_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   // memory model: deselected lanes drive a fixed pattern
   logic [15:0] marr [256];
   initial for (int i = 0; i < 256; i++) marr[i] = 16'h0000;
   assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ?
      { mem_bsel_n[1] ? 8'hA5 : marr[mem_addr[7:0]][15:8],
        mem_bsel_n[0] ? 8'h5A : marr[mem_addr[7:0]][7:0] } : 16'hFFFF;
   always @(posedge clk)
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
         if (!mem_bsel_n[0]) marr[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
         if (!mem_bsel_n[1]) marr[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
      end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // results of the last access
   int   done_idx, n_ce, n_we, n_oe, first_dq;
   logic last_we_hi, addr_chg, bsel_bad, data_bad, contend, rv;
   logic [15:0] rd;

   task automatic do_access(input logic wr, input logic [16:0] a,
                            input logic [15:0] d, input logic [1:0] be);
      logic [16:0] a0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n_ce = 0; n_we = 0; n_oe = 0; first_dq = 0; done_idx = 0;
      last_we_hi = 1'b0; addr_chg = 1'b0; bsel_bad = 1'b0; data_bad = 1'b0;
      contend = 1'b0; rv = 1'b0; rd = '0; a0 = '0;
      for (int idx = 1; idx < 64; idx++) begin
         if (mem_dq_oe && !mem_oe_n) contend = 1'b1;
         if (mem_dq_oe && first_dq == 0) first_dq = idx;
         if (req_ready) begin
            done_idx = idx; rv = rsp_valid; rd = rsp_rdata;
            break;
         end
         if (!mem_ce_n) begin
            if (n_ce == 0) a0 = mem_addr;
            else if (mem_addr != a0) addr_chg = 1'b1;
            if (mem_bsel_n != ~be) bsel_bad = 1'b1;
            last_we_hi = mem_we_n;
            n_ce++;
         end
         if (!mem_we_n) begin
            n_we++;
            if (mem_dq_out != d) data_bad = 1'b1;
         end
         if (!mem_oe_n) n_oe++;
         @(negedge clk);
      end
      // R2: idle standby once the access is over
      chk(mem_ce_n && mem_oe_n && mem_we_n && (mem_bsel_n == 2'b11), "R2 standby after access",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n}, 5'h1F);
   endtask

   task automatic t_reset();
      chk(mem_ce_n && mem_oe_n && mem_we_n && (mem_bsel_n == 2'b11) && !mem_dq_oe,
          "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe}, 6'h3E);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 ready after reset",
          {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
   endtask

   task automatic t_write_full();
      do_access(1'b1, 17'h5, 16'h1234, 2'b11);
      chk(n_we == EXP_WP, "R5 R10 we low cycles", n_we, EXP_WP);
      chk(n_ce == EXP_WT, "R6 R10 ce low cycles", n_ce, EXP_WT);
      chk(last_we_hi, "R6 we high before release", last_we_hi, 1);
      chk(done_idx == EXP_WT + 1, "R6 ready index", done_idx, EXP_WT + 1);
      chk(n_oe == 0 && !contend, "R5 R8 oe high in write", n_oe, 0);
      chk(!addr_chg && !bsel_bad && !data_bad, "R7 addr/bsel/data steady",
          {addr_chg, bsel_bad, data_bad}, 0);
      chk(first_dq == 1, "R8 no gap without prior read", first_dq, 1);
   endtask

   task automatic t_read_full();
      do_access(1'b0, 17'h5, 16'h0, 2'b11);
      chk(n_oe == EXP_RD && n_ce == EXP_RD, "R3 R10 read strobe cycles", n_oe, EXP_RD);
      chk(n_we == 0, "R3 we high in read", n_we, 0);
      chk(done_idx == EXP_RD + 1 && rv, "R3 response index", done_idx, EXP_RD + 1);
      chk(rd == 16'h1234, "R3 read data", rd, 16'h1234);
   endtask

   task automatic t_write_upper_after_read();
      do_access(1'b1, 17'h5, 16'hAB77, 2'b10);
      chk(first_dq == 2, "R8 turnaround cycle", first_dq, 2);
      chk(done_idx == EXP_WT + 2, "R8 ready index after turn", done_idx, EXP_WT + 2);
      chk(!bsel_bad && !contend, "R4 R8 upper select only", {bsel_bad, contend}, 0);
      do_access(1'b0, 17'h5, 16'h0, 2'b11);
      chk(rd == 16'hAB34, "R4 low byte kept", rd, 16'hAB34);
   endtask

   task automatic t_read_lanes();
      do_access(1'b0, 17'h5, 16'h0, 2'b01);
      chk(!bsel_bad && rd == 16'h0034, "R4 low lane only read", rd, 16'h0034);
      do_access(1'b0, 17'h5, 16'h0, 2'b10);
      chk(!bsel_bad && rd == 16'hAB00, "R4 high lane only read", rd, 16'hAB00);
   endtask

   task automatic t_zero_mask();
      do_access(1'b1, 17'h5, 16'hFFFF, 2'b00);
      chk(n_ce == 0 && done_idx == 1, "R9 zero-mask write no cycle", n_ce, 0);
      do_access(1'b0, 17'h5, 16'h0, 2'b00);
      chk(n_ce == 0 && done_idx == 1 && rv && rd == 16'h0, "R9 zero-mask read resp",
          {rv, rd}, 17'h10000);
      do_access(1'b0, 17'h5, 16'h0, 2'b11);
      chk(rd == 16'hAB34, "R9 memory unchanged", rd, 16'hAB34);
   endtask

   task automatic t_write_write();
      do_access(1'b1, 17'h9, 16'hC3C3, 2'b11);
      do_access(1'b1, 17'hA, 16'h5A5A, 2'b11);
      chk(first_dq == 1 && done_idx == EXP_WT + 1, "R8 no turn between writes", first_dq, 1);
      do_access(1'b0, 17'h9, 16'h0, 2'b11);
      chk(rd == 16'hC3C3, "R5 second address intact", rd, 16'hC3C3);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      t_write_full();
      t_read_full();
      t_write_upper_after_read();
      t_read_lanes();
      t_zero_mask();
      t_write_write();
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule